// File: doc/BRIEF.md
# Sync-Embedded Frame Stream Composer

The composer produces, one byte at a time, the complete content of a waveform framebuffer for one video frame. The default geometry is 640x480 with standard blanking. Every byte packs a vertical-sync level in bit 7, a horizontal-sync level in bit 6 (both active low) and a colour in bits 5:0. A scanout engine later replays these bytes at the dot clock. The bytes are written in exactly the order that engine plays them, so blanking and sync intervals are stored as data, next to the picture.

The frame opens with the vertical back-porch lines, not with line zero or the sync pulse. It closes with a short tail in which both syncs are high. That tail follows the vertical-sync lines, and its rising vertical-sync edge is what makes the scanout engine wrap its address. Colours for visible positions come from an external source through a request/response port addressed by row and column. Bytes leave through a valid/ready handshake. Geometry is set by parameters: the bench uses a scaled-down frame, and the defaults give the 800x525 layout.

Top module: `sfc_frame_composer`

## Requirements
- R1: Each line is 16 front-porch bytes, then 96 horizontal-sync bytes with bit 6 low, then 48 back-porch bytes, then 640 active-column bytes. Bit 6 is high in every byte outside the horizontal-sync run.
- R2: Porch, sync and blank-line bytes carry colour bits 5:0 equal to 0.
- R3: Lines are emitted as 33 vertical back-porch lines, then 480 visible lines, then 10 vertical front-porch lines, then 2 vertical-sync lines in which bit 7 is low in every byte.
- R4: Bit 7 is high in every byte outside the two vertical-sync lines, including the horizontal-sync bytes of those other lines.
- R5: After the vertical-sync lines, exactly 2 tail bytes of value 0xC0 close the frame, for 525x800+2 bytes in total.
- R6: A visible byte has bits 7:6 = 11 and carries in bits 5:0 the colour returned for row 0..479 (line index minus the back-porch line count) and column 0..639 (position within the line minus 160).
- R7: While a visible byte is pending and the colour port is not ready, out_valid_o is low and the requested row and column stay unchanged.
- R8: A byte offered with out_valid_o high and not accepted stays offered unchanged on the next cycle.
- R9: done_o is high for exactly one cycle, the cycle after the last tail byte is accepted. From then on the block is idle with out_valid_o low.
- R10: start_i while idle begins a frame at its first back-porch byte on the next cycle. start_i during a frame has no effect on the byte stream.
- R11: During reset, out_valid_o, done_o and pix_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame when idle |
| pix_req_o | output | 1 | Colour wanted for pix_row_o/pix_col_o |
| pix_row_o | output | ROW_W (9) | Visible row of the pending byte |
| pix_col_o | output | COL_W (10) | Visible column of the pending byte |
| pix_ready_i | input | 1 | pix_color_i is valid for the requested position |
| pix_color_i | input | COLOR_W (6) | Colour for the requested position |
| out_valid_o | output | 1 | out_byte_o is offered |
| out_ready_i | input | 1 | Sink accepts out_byte_o |
| out_byte_o | output | COLOR_W+2 (8) | Framebuffer byte {vsync_n, hsync_n, colour} |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench goes after the seams of the frame. These are the edge between the last horizontal-sync byte and the back porch, and the first and last visible lines and columns, where an off-by-one design would shift a sync pulse or fetch colour for a wrong row or column. They also include the transition into the vertical-sync lines, where a design that clears bit 7 only during the horizontal-sync run would be caught, and the two-byte tail, where a missing or extra tail byte changes the frame length. Random stalls on both the colour port and the output sink expose a design that advances on an unaccepted byte or drops a request. Start pulses in mid-frame catch a composer that restarts and truncates the frame.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int VS_BIT = 7;
  localparam int HS_BIT = 6;
  function automatic int safe_clog2(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sfc_line_timer.sv
module sfc_line_timer #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int TAIL    = 2,
  localparam int HW = sfc_pkg::safe_clog2(H_TOTAL),
  localparam int VW = sfc_pkg::safe_clog2(V_TOTAL),
  localparam int TW = sfc_pkg::safe_clog2(TAIL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          tail_o,
  output logic          last_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic [TW-1:0] t_q;
  logic          tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q    <= '0;
      v_q    <= '0;
      t_q    <= '0;
      tail_q <= 1'b0;
    end else if (clear_i) begin
      h_q    <= '0;
      v_q    <= '0;
      t_q    <= '0;
      tail_q <= 1'b0;
    end else if (step_i) begin
      if (tail_q) begin
        t_q <= t_q + 1'b1;
      end else if (h_q == HW'(H_TOTAL - 1)) begin
        h_q <= '0;
        if (v_q == VW'(V_TOTAL - 1)) tail_q <= 1'b1;
        else                         v_q <= v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign h_o    = h_q;
  assign v_o    = v_q;
  assign tail_o = tail_q;
  assign last_o = tail_q && (t_q == TW'(TAIL - 1));
endmodule

// File: rtl/sfc_byte_former.sv
module sfc_byte_former #(
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int H_TOTAL = 800,
  parameter int V_BP    = 33,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_TOTAL = 525,
  parameter int COLOR_W = 6,
  parameter int ROW_W   = 9,
  parameter int COL_W   = 10,
  localparam int HW = sfc_pkg::safe_clog2(H_TOTAL),
  localparam int VW = sfc_pkg::safe_clog2(V_TOTAL),
  localparam int H_BLANK = H_FP + H_SYNC + H_BP,
  localparam int V_SYNC0 = V_BP + V_VIS + V_FP
) (
  input  logic [HW-1:0]        h_i,
  input  logic [VW-1:0]        v_i,
  input  logic                 tail_i,
  input  logic [COLOR_W-1:0]   color_i,
  output logic                 vis_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [COLOR_W+1:0]   byte_o
);
  logic hs_n, vs_n, vis_line;

  assign vis_line = (v_i >= VW'(V_BP)) && (v_i < VW'(V_BP + V_VIS));
  assign vis_o    = !tail_i && vis_line && (h_i >= HW'(H_BLANK));
  assign hs_n     = tail_i || !((h_i >= HW'(H_FP)) && (h_i < HW'(H_FP + H_SYNC)));
  assign vs_n     = tail_i || (v_i < VW'(V_SYNC0));
  assign row_o    = ROW_W'(v_i - VW'(V_BP));
  assign col_o    = COL_W'(h_i - HW'(H_BLANK));

  always_comb begin
    byte_o = '0;
    byte_o[sfc_pkg::VS_BIT] = vs_n;
    byte_o[sfc_pkg::HS_BIT] = hs_n;
    byte_o[COLOR_W-1:0]     = vis_o ? color_i : '0;
  end
endmodule

// File: rtl/sfc_frame_composer.sv
module sfc_frame_composer #(
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int H_VIS   = 640,
  parameter int V_BP    = 33,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int TAIL    = 2,
  parameter int COLOR_W = 6,
  localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_VIS,
  localparam int V_TOTAL = V_BP + V_VIS + V_FP + V_SYNC,
  localparam int ROW_W = sfc_pkg::safe_clog2(V_VIS),
  localparam int COL_W = sfc_pkg::safe_clog2(H_VIS),
  localparam int BYTE_W = COLOR_W + 2,
  localparam int HW = sfc_pkg::safe_clog2(H_TOTAL),
  localparam int VW = sfc_pkg::safe_clog2(V_TOTAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               pix_req_o,
  output logic [ROW_W-1:0]   pix_row_o,
  output logic [COL_W-1:0]   pix_col_o,
  input  logic               pix_ready_i,
  input  logic [COLOR_W-1:0] pix_color_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BYTE_W-1:0]  out_byte_o,
  output logic               done_o
);
  logic          run_q, done_q, fire, last, vis, tail, clear;
  logic [HW-1:0] h;
  logic [VW-1:0] v;

  assign clear       = !run_q && start_i;
  assign out_valid_o = run_q && (!vis || pix_ready_i);
  assign fire        = out_valid_o && out_ready_i;
  assign pix_req_o   = run_q && vis;
  assign done_o      = done_q;

  sfc_line_timer #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .TAIL(TAIL)) u_timer (
    .clk_i, .rst_ni, .clear_i(clear), .step_i(fire),
    .h_o(h), .v_o(v), .tail_o(tail), .last_o(last)
  );

  sfc_byte_former #(
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_TOTAL(H_TOTAL),
    .V_BP(V_BP), .V_VIS(V_VIS), .V_FP(V_FP), .V_TOTAL(V_TOTAL),
    .COLOR_W(COLOR_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_former (
    .h_i(h), .v_i(v), .tail_i(tail), .color_i(pix_color_i),
    .vis_o(vis), .row_o(pix_row_o), .col_o(pix_col_o), .byte_o(out_byte_o)
  );

  // start is only sampled while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire && last;
      if (clear)              run_q <= 1'b1;
      else if (fire && last)  run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_frame_composer_chk.sv
module sfc_frame_composer_chk #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_req_o,
  input logic [ROW_W-1:0]  pix_row_o,
  input logic [COL_W-1:0]  pix_col_o,
  input logic              pix_ready_i,
  input logic [BYTE_W-3:0] pix_color_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_byte_o,
  input logic              done_o
);
  a_r2_blank_color_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !pix_req_o |-> out_byte_o[BYTE_W-3:0] == '0);

  a_r6_visible_color: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pix_req_o |-> out_byte_o == {2'b11, pix_color_i});

  a_r7_stall_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o && !pix_ready_i |-> !out_valid_o);

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o && !(out_valid_o && out_ready_i) |=>
      pix_req_o && $stable(pix_row_o) && $stable(pix_col_o));

  a_r8_byte_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !pix_req_o |=> out_valid_o && $stable(out_byte_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o && !pix_req_o);
endmodule

bind sfc_frame_composer sfc_frame_composer_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_req_o(pix_req_o), .pix_row_o(pix_row_o),
  .pix_col_o(pix_col_o), .pix_ready_i(pix_ready_i), .pix_color_i(pix_color_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_byte_o(out_byte_o),
  .done_o(done_o)
);

// File: tb/sfc_frame_composer_test.sv
`timescale 1ns/1ps
module sfc_frame_composer_test;
  localparam int H_FP = 4, H_SYNC = 6, H_BP = 3, H_VIS = 8;
  localparam int V_BP = 3, V_VIS = 5, V_FP = 2, V_SYNC = 2, TAIL = 2;
  localparam int LW = H_FP + H_SYNC + H_BP + H_VIS;
  localparam int HB = H_FP + H_SYNC + H_BP;
  localparam int NL = V_BP + V_VIS + V_FP + V_SYNC;
  localparam int TOTAL = NL * LW + TAIL;
  localparam int ROW_W = $clog2(V_VIS);
  localparam int COL_W = $clog2(H_VIS);

  logic clk_i = 0, rst_ni = 0, start_i = 0, pix_ready_i = 0, out_ready_i = 0;
  logic pix_req_o, out_valid_o, done_o;
  logic [ROW_W-1:0] pix_row_o;
  logic [COL_W-1:0] pix_col_o;
  logic [5:0] pix_color_i;
  logic [7:0] out_byte_o;

  always #4 clk_i = ~clk_i;

  sfc_frame_composer #(
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_VIS(H_VIS),
    .V_BP(V_BP), .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .TAIL(TAIL), .COLOR_W(6)
  ) uut (.*);

  function automatic logic [5:0] colf(int r, int c);
    return 6'((r * 5 + c * 3 + 1) & 63);
  endfunction

  always_comb pix_color_i = colf(int'(pix_row_o), int'(pix_col_o));

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    bit run = 0, e_done = 0, nd, fire, tl, e_vis, e_vs, e_hs, e_valid;
    int idx = 0, frames = 0, cycles = 0, h = 0, v = 0, mode, idle_run = 0;
    logic [7:0] e_byte;
    string tag;

    // R11 reset state
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 0, "R11 valid in reset", 32'(out_valid_o), 0);
    chk(done_o == 0, "R11 done in reset", 32'(done_o), 0);
    chk(pix_req_o == 0, "R11 req in reset", 32'(pix_req_o), 0);
    rst_ni = 1;

    while (frames < 6) begin
      @(negedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog", 32'(cycles), 0);
        break;
      end
      mode = frames;
      out_ready_i = (mode == 0 || mode == 1) ? 1'b1 : ($urandom_range(0, 3) != 0);
      pix_ready_i = (mode == 0 || mode == 2) ? 1'b1 : ($urandom_range(0, 2) != 0);
      if (!run) start_i = (idle_run >= 3) ? 1'b1 : 1'b0;
      else      start_i = (mode >= 3) ? ($urandom_range(0, 7) == 0) : 1'b0; // R10 noise
      #1;

      tl = (idx >= NL * LW);
      if (!tl) begin v = idx / LW; h = idx % LW; end
      e_vis  = !tl && v >= V_BP && v < V_BP + V_VIS && h >= HB;
      e_vs   = tl || v < V_BP + V_VIS + V_FP;           // R3, R4
      e_hs   = tl || !(h >= H_FP && h < H_FP + H_SYNC); // R1
      e_byte = {e_vs, e_hs, e_vis ? colf(v - V_BP, h - HB) : 6'd0};
      e_valid = run && (!e_vis || pix_ready_i);

      if (run && e_vis && !pix_ready_i) tag = "R7 stall";
      else if (!run) tag = "R10 idle";
      else tag = "R8 valid";
      chk(out_valid_o == e_valid, tag, 32'(out_valid_o), 32'(e_valid));
      chk(done_o == e_done, "R9 done", 32'(done_o), 32'(e_done));
      chk(pix_req_o == (run && e_vis), "R7 req", 32'(pix_req_o), 32'(run && e_vis));
      if (e_valid) begin
        if (tl) tag = "R5 tail";
        else if (e_vis) tag = "R6 visible";
        else if (!e_vs) tag = "R3 vsync line";
        else if (!e_hs) tag = "R1 hsync";
        else tag = "R2 blank";
        chk(out_byte_o == e_byte, tag, 32'(out_byte_o), 32'(e_byte));
      end
      if (run && e_vis) begin
        chk(int'(pix_row_o) == v - V_BP, "R6 row", 32'(pix_row_o), 32'(v - V_BP));
        chk(int'(pix_col_o) == h - HB, "R6 col", 32'(pix_col_o), 32'(h - HB));
      end

      fire = e_valid && out_ready_i;
      nd = 0;
      if (run) begin
        idle_run = 0;
        if (fire) begin
          if (idx == TOTAL - 1) begin run = 0; nd = 1; frames++; end
          else idx++;
        end
      end else begin
        idle_run++;
        if (start_i) begin run = 1; idx = 0; idle_run = 0; end
      end
      e_done = nd;
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule